// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. When it sees a start request, it sets up a trial code, drives that code in parallel to an external DAC, and reads back a single comparator bit. That bit is high when the analog input is above the DAC output. The controller finds the result one bit per clock, starting at the most significant bit. A trial bit stays set when the comparator reports the input above the DAC level, and is cleared otherwise.

When the last bit has been decided, the code is copied into a result latch. The latch keeps that value until the next conversion finishes. A processor reads the latch like a memory location: the data output is enabled only while chip-select and read are both asserted. The bus driver is modelled as an enable flag plus a data word that is forced to zero while the flag is low. A start request that arrives in the middle of a conversion drops the search in progress and begins again at the most significant bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `busy_o` and `eoc_o` are 0, `dac_code_o` is 0, and the result latch holds 0.
- R2: If `start_i` is 1 at a clock edge, then after that edge `busy_o` is 1 and `dac_code_o` is 8'h80, which is the top bit alone.
- R3: Each clock after the start edge tests one bit, from bit 7 down to bit 0. At that edge:
  - the bit under test keeps its 1 if `cmp_i` is 1, and becomes 0 if `cmp_i` is 0;
  - the next lower bit becomes 1;
  - the bits above the tested bit do not change;
  - the bits below the new trial bit stay 0.
- R4: With an ideal comparator (`cmp_i` = input level > `dac_code_o`), the final code is the largest code that lies strictly below the input level. An input level of 0 gives code 0.
- R5: `busy_o` stays 1 for exactly 9 cycles after the start edge: 8 trial cycles and one load cycle. In the cycle after that, `busy_o` is 0 and `eoc_o` is 1 for exactly one cycle.
- R6: A start during a conversion brings `dac_code_o` back to 8'h80 and keeps `busy_o` at 1. The full 9-cycle sequence is counted again from the new start edge, and the abandoned search never reaches the result latch.
- R7: The result latch changes only in the load cycle, and it takes the finished search code. During a later conversion it still holds the previous result.
- R8: `bus_oe_o` is 1, and `bus_data_o` equals the latched result, only while both `cs_i` and `rd_i` are 1. Otherwise `bus_oe_o` is 0 and `bus_data_o` is 0.
- R9: While idle, with no start, `dac_code_o` keeps the last finished code, and changes on `cmp_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start (or restart) a conversion |
| cmp_i | input | 1 | Comparator: 1 when the analog input is above the DAC output |
| dac_code_o | output | 8 | Trial code to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| cs_i | input | 1 | Bus chip select |
| rd_i | input | 1 | Bus read strobe |
| bus_data_o | output | 8 | Result data toward the bus |
| bus_oe_o | output | 1 | Bus drive enable (high-impedance when 0) |

## Verification
Several invariants are checked by the assertions on every cycle:
- at most one trial bit is active at a time;
- the trial bit is set and every bit below it is clear;
- each decision follows the comparator;
- a restart reloads the top bit;
- the latch changes only on a load, and it matches the DAC code when the end pulse fires;
- the DAC code stays still while the block is idle.

Only the bench's scenarios can show the rest:
- the exact nine-cycle busy window;
- the mapping from input level to final code at the edges of the range (0, 1, 128, 129, 256);
- that a restarted search leaves the old result readable;
- how the bus behaves when just one of chip-select and read is asserted.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_TRIAL = 2'd1,
      PH_LOAD  = 2'd2
   } sar_phase_e;

   function automatic int unsigned sar_cycles(input int unsigned width);
      return width + 1;
   endfunction
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [WIDTH-1:0] ptr_o,
   output logic             load_o,
   output logic             busy_o,
   output logic             eoc_o
);
   localparam logic [WIDTH-1:0] MSB_ONEHOT = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_sequencer: WIDTH must be at least 2");
      end
   endgenerate

   sar_phase_e       phase_q;
   logic [WIDTH-1:0] ptr_q;
   logic             eoc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ptr_q   <= '0;
         eoc_q   <= 1'b0;
      end else begin
         eoc_q <= (phase_q == PH_LOAD) && !start_i;
         if (start_i) begin
            phase_q <= PH_TRIAL;
            ptr_q   <= MSB_ONEHOT;
         end else begin
            unique case (phase_q)
               PH_TRIAL: begin
                  ptr_q <= ptr_q >> 1;
                  if (ptr_q[0]) phase_q <= PH_LOAD;
               end
               PH_LOAD:  phase_q <= PH_IDLE;
               default:  phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign ptr_o  = ptr_q;
   assign load_o = (phase_q == PH_LOAD) && !start_i;
   assign busy_o = (phase_q != PH_IDLE);
   assign eoc_o  = eoc_q;

   // R3: one trial bit at most
   a_r3_single_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr_q));
   // R6: any start reloads the top bit and enters the trial phase
   a_r6_restart_msb: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (ptr_q == MSB_ONEHOT) && (phase_q == PH_TRIAL));
   // R5: last trial is followed by the load phase
   a_r5_last_trial_to_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[0] && !start_i) |=> (phase_q == PH_LOAD));
   // R5: end pulse lasts one cycle
   a_r5_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_q |=> !eoc_q);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             cmp_i,
   input  logic [WIDTH-1:0] ptr_i,
   output logic [WIDTH-1:0] code_o
);
   logic [WIDTH-1:0] code_q;
   logic [WIDTH-1:0] code_d;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         if (i == WIDTH - 1) begin : g_top
            assign code_d[i] = restart_i ? 1'b1 :
                               (ptr_i[i] ? cmp_i : code_q[i]);
         end else begin : g_lower
            assign code_d[i] = restart_i    ? 1'b0  :
                               ptr_i[i]     ? cmp_i :
                               ptr_i[i+1]   ? 1'b1  : code_q[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
   end

   assign code_o = code_q;

   // R3: the bit under trial is set while a trial runs
   a_r3_trial_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|ptr_i) |-> ((code_q & ptr_i) == ptr_i));
   // R3: bits below the trial bit are clear
   a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|ptr_i) |-> ((code_q & (ptr_i - 1'b1)) == '0));
   // R3: the decision on the tested bit follows the comparator
   a_r3_decision: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ptr_i) && !restart_i) |=>
         ((code_q & $past(ptr_i)) == ($past(cmp_i) ? $past(ptr_i) : '0)));
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] code_i,
   input  logic             cs_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] latch_o,
   output logic [WIDTH-1:0] data_o,
   output logic             oe_o
);
   logic [WIDTH-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '0;
      else if (load_i) latch_q <= code_i;
   end

   assign oe_o    = cs_i & rd_i;
   assign latch_o = latch_q;

   generate
      if (IDLE_ZERO) begin : g_gated
         assign data_o = oe_o ? latch_q : '0;
      end else begin : g_open
         assign data_o = latch_q;
      end
   endgenerate

   // R7: a load captures the finished code
   a_r7_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (latch_q == $past(code_i)));
   // R7: without a load the latch holds
   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(latch_q));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic [WIDTH-1:0] dac_code_o,
   output logic             busy_o,
   output logic             eoc_o,
   input  logic             cs_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] bus_data_o,
   output logic             bus_oe_o
);
   logic [WIDTH-1:0] ptr_w;
   logic [WIDTH-1:0] code_w;
   logic [WIDTH-1:0] result_w;
   logic             load_w;

   sar_sequencer #(.WIDTH(WIDTH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .ptr_o   (ptr_w),
      .load_o  (load_w),
      .busy_o  (busy_o),
      .eoc_o   (eoc_o)
   );

   sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (start_i),
      .cmp_i     (cmp_i),
      .ptr_i     (ptr_w),
      .code_o    (code_w)
   );

   sar_result_port #(.WIDTH(WIDTH), .IDLE_ZERO(IDLE_ZERO)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .code_i  (code_w),
      .cs_i    (cs_i),
      .rd_i    (rd_i),
      .latch_o (result_w),
      .data_o  (bus_data_o),
      .oe_o    (bus_oe_o)
   );

   assign dac_code_o = code_w;

   // R9: idle without start leaves the DAC code still
   a_r9_idle_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(dac_code_o));
   // R5: end pulse only when no longer busy
   a_r5_eoc_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> !busy_o);
   // R7: at end of conversion the latch carries the searched code
   a_r7_result_matches: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> (result_w == dac_code_o));
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cs_i = 1'b0;
   logic       rd_i = 1'b0;
   logic       cmp_i;
   logic [7:0] dac_code_o;
   logic [7:0] bus_data_o;
   logic       busy_o, eoc_o, bus_oe_o;
   int         vin = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   logic [7:0] last_result = 8'h00;

   always #5 clk = ~clk;

   assign cmp_i = (vin > int'(dac_code_o));

   sar_adc_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .dac_code_o(dac_code_o), .busy_o(busy_o), .eoc_o(eoc_o),
      .cs_i(cs_i), .rd_i(rd_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic read_bus(output logic [7:0] d, output logic oe);
      cs_i = 1'b1; rd_i = 1'b1; #1;
      d = bus_data_o; oe = bus_oe_o;
      cs_i = 1'b0; rd_i = 1'b0; #1;
   endtask

   function automatic logic [7:0] expect_code(input int v);
      return (v <= 0) ? 8'd0 : ((v > 256) ? 8'd255 : 8'(v - 1));
   endfunction

   // start pulse; checks R2 right after the start edge
   task automatic launch(input int v);
      @(negedge clk); vin = v; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R2 busy after start", busy_o, 1);
      chk("R2 dac top bit", dac_code_o, 8'h80);
   endtask

   // run the 8 trials and the load; checks R3, R4, R5, R7, R8
   task automatic finish(input int v);
      logic [7:0] model = 8'h80;
      logic [7:0] d;
      logic       oe;
      for (int b = 7; b >= 0; b--) begin
         if (!(v > int'(model))) model[b] = 1'b0;
         if (b > 0) model[b-1] = 1'b1;
         @(negedge clk);
         chk("R3 trial step", dac_code_o, model);
      end
      chk("R5 busy through load", busy_o, 1);
      chk("R5 no early eoc", eoc_o, 0);
      @(negedge clk);
      chk("R5 busy drops", busy_o, 0);
      chk("R5 eoc pulse", eoc_o, 1);
      chk("R4 final code", dac_code_o, expect_code(v));
      read_bus(d, oe);
      chk("R8 read enable", oe, 1);
      chk("R7 latched result", d, expect_code(v));
      last_result = expect_code(v);
      @(negedge clk);
      chk("R5 eoc one cycle", eoc_o, 0);
   endtask

   task automatic t_reset();
      logic [7:0] d; logic oe;
      chk("R1 busy", busy_o, 0);
      chk("R1 eoc", eoc_o, 0);
      chk("R1 dac", dac_code_o, 0);
      read_bus(d, oe);
      chk("R1 latch", d, 0);
   endtask

   task automatic t_convert(input int v);
      launch(v);
      finish(v);
   endtask

   task automatic t_restart();
      logic [7:0] d; logic oe;
      launch(200);
      repeat (3) @(negedge clk);
      read_bus(d, oe);
      chk("R7 old result kept mid-search", d, last_result);
      vin = 37; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R6 restart dac top bit", dac_code_o, 8'h80);
      chk("R6 restart busy", busy_o, 1);
      read_bus(d, oe);
      chk("R6 abandoned search not latched", d, last_result);
      finish(37);
   endtask

   task automatic t_bus_gating();
      cs_i = 1'b1; rd_i = 1'b0; #1;
      chk("R8 cs only oe", bus_oe_o, 0);
      chk("R8 cs only data", bus_data_o, 0);
      cs_i = 1'b0; rd_i = 1'b1; #1;
      chk("R8 rd only oe", bus_oe_o, 0);
      chk("R8 rd only data", bus_data_o, 0);
      rd_i = 1'b0; #1;
      chk("R8 idle oe", bus_oe_o, 0);
   endtask

   task automatic t_idle_hold();
      logic [7:0] d; logic oe;
      vin = 0;
      repeat (4) @(negedge clk);
      chk("R9 dac holds with cmp low", dac_code_o, last_result);
      vin = 256;
      repeat (4) @(negedge clk);
      chk("R9 dac holds with cmp high", dac_code_o, last_result);
      chk("R9 still idle", busy_o, 0);
      read_bus(d, oe);
      chk("R7 latch holds when idle", d, last_result);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_convert(171);
      t_convert(0);
      t_convert(1);
      t_convert(2);
      t_convert(128);
      t_convert(129);
      t_convert(256);
      t_convert(86);
      t_restart();
      t_bus_gating();
      t_idle_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule